// File: doc/BRIEF.md
# Write-Back Data Cache with Half-Line Dirty Tracking

The block is a small four-way set-associative data cache that sits between a processor load/store port and a plain word-wide memory bus. Every line holds eight 32-bit words, a physical tag, a valid flag and two dirty flags: one for words 0 to 3, one for words 4 to 7. Stores that hit only mark the half they touched. A store miss first brings the line in (write-allocate) and then updates it. When a line must make room, only its dirty halves go back to memory. Each goes as its own four-beat burst, and the address is built from the tag kept with the line.

The processor side uses a valid/ready request channel. The cache raises `req_ready` only when it is idle. Once a request is taken, `req_ready` stays low until the single-cycle `rsp_valid` pulse that closes the request, so the processor stalls for the whole miss and write-back sequence. The response channel has no back-pressure: the processor must take `rsp_valid` in the cycle it appears. The memory side is valid/ready as well. The cache holds `mem_valid`, address, direction, write data and `mem_last` steady until `mem_ready` is seen. Read data is taken from `mem_rdata` in the cycle that `mem_ready` is high. When `cache_en` is low at acceptance, the request bypasses the cache: it becomes one memory beat and leaves the arrays untouched.

Address layout: bits [1:0] byte offset (ignored; whole-word access), bits [4:2] word in line, bits [8:5] set, bits [31:9] tag.

Top module: `hd_wb_dcache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, and `mem_valid` and `rsp_valid` are low. The first cached access to any address is a miss.
- R2: Four lines whose addresses share a set index can be resident at the same time. At most one way matches a lookup.
- R3: A cached miss reads the line with an eight-beat read burst at ascending word addresses from the line base, with word 0 first and `mem_last` on the eighth beat. A read then returns the requested word.
- R4: A cached access that hits produces `rsp_valid` in the cycle after acceptance, with no memory beat.
- R5: A cached read returns the most recently stored value for that word. A store hit writes the word and sets the dirty flag of only its half: words 0 to 3 for word index bit 2 = 0, words 4 to 7 for bit 2 = 1. A store miss refills the line first and then writes the word.
- R6: When a valid victim is replaced, each dirty half is written back as a four-beat write burst at `{stored tag, set, half, beat, 2'b00}` with `mem_last` on the fourth beat. The lower half goes first, and a clean half sends no beat. The write-back precedes the refill.
- R7: The victim is the lowest-numbered invalid way of the set. When all four ways are valid, it is the way named by a per-set round-robin pointer. The pointer starts at way 0 and steps by one each time it supplies a victim.
- R8: With `cache_en` low at acceptance, the access is one memory beat at the request word address, with `mem_last` set and the request's direction and write data. The cache contents do not change, so a later cached access to that line misses.
- R9: From acceptance until `rsp_valid`, `req_ready` stays low. Each request gets exactly one single-cycle `rsp_valid`, and the cache is ready again in the following cycle.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we`, `mem_wdata` and `mem_last` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | High: request goes through the cache; low: bypass |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache idle and accepting a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, valid with rsp_valid on a load |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_wdata | output | 32 | Write beat data |
| mem_last | output | 1 | Final beat of a burst |
| mem_rdata | input | 32 | Read beat data, valid while mem_ready is high |

## Verification
Eviction write-back and refill fall inside one request, and the harder overlap is a store that misses on a set whose round-robin victim holds dirty data. In that request the stored tag and dirty halves of the old line must be used for the write-back, and the new address must be used for the refill and the store. A directed sequence dirties the upper half of one way and both halves of another, then forces three more tags into that set. Long random runs confined to four sets produce many dirty-victim store misses while `mem_ready` is dropped at random. Each request's beat trace and returned data are compared against a bench model of tags, dirty halves, victim pointers and memory.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WBACK,
    ST_FILL,
    ST_BYPASS
  } dc_state_e;
endpackage

// File: rtl/dc_tagstore.sv
// Tag, valid and per-half dirty storage with parallel compare.
module dc_tagstore #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int TAGW = 23,
  parameter int SW   = $clog2(SETS),
  parameter int WW   = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SW-1:0]              look_set,
  input  logic [TAGW-1:0]            look_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic [WAYS-1:0]            valid_vec,
  output logic [WAYS-1:0][1:0]       dirty_vec,
  output logic [WAYS-1:0][TAGW-1:0]  tag_vec,
  input  logic                       fill_en,
  input  logic [WW-1:0]              fill_way,
  input  logic                       mark_en,
  input  logic [WW-1:0]              mark_way,
  input  logic                       mark_half
);
  logic [TAGW-1:0] tags [SETS][WAYS];
  logic            vld  [SETS][WAYS];
  logic [1:0]      drt  [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w] <= 1'b0;
          drt[s][w] <= 2'b00;
        end
    end else if (fill_en) begin
      vld[look_set][fill_way] <= 1'b1;
      drt[look_set][fill_way] <= 2'b00;
    end else if (mark_en) begin
      drt[look_set][mark_way][mark_half] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tags[look_set][fill_way] <= look_tag;
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign tag_vec[g]   = tags[look_set][g];
    assign valid_vec[g] = vld[look_set][g];
    assign dirty_vec[g] = drt[look_set][g];
    assign hit_vec[g]   = vld[look_set][g] && (tags[look_set][g] == look_tag);
  end
endmodule

// File: rtl/dc_datastore.sv
// Line data array: one write port, one combinational read port, shared set.
module dc_datastore #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int WORDS = 8,
  parameter int DW    = 32,
  parameter int SW    = $clog2(SETS),
  parameter int WW    = $clog2(WAYS),
  parameter int XW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic [SW-1:0] set_idx,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_way,
  input  logic [XW-1:0] wr_word,
  input  logic [DW-1:0] wr_data,
  input  logic [WW-1:0] rd_way,
  input  logic [XW-1:0] rd_word,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = SETS * WAYS * WORDS;
  localparam int AWID  = SW + WW + XW;

  logic [DW-1:0] arr [DEPTH];

  logic [AWID-1:0] wr_ix, rd_ix;
  assign wr_ix = {set_idx, wr_way, wr_word};
  assign rd_ix = {set_idx, rd_way, rd_word};

  always_ff @(posedge clk) begin
    if (wr_en) arr[wr_ix] <= wr_data;
  end

  assign rd_data = arr[rd_ix];
endmodule

// File: rtl/dc_victim.sv
// Victim choice: lowest invalid way, else per-set round-robin pointer.
module dc_victim #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int SW   = $clog2(SETS),
  parameter int WW   = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW-1:0]   set_idx,
  input  logic [WAYS-1:0] valid_vec,
  input  logic            adv,
  output logic [WW-1:0]   vic_way,
  output logic            use_rr
);
  logic [WW-1:0] rr [SETS];

  always_comb begin
    vic_way = rr[set_idx];
    use_rr  = 1'b1;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        vic_way = WW'(i);
        use_rr  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr[s] <= '0;
    end else if (adv) begin
      rr[set_idx] <= rr[set_idx] + WW'(1);
    end
  end
endmodule

// File: rtl/hd_wb_dcache.sv
module hd_wb_dcache #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int WORDS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cache_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_last,
  input  logic [DW-1:0] mem_rdata
);
  import dc_pkg::*;

  localparam int OFS    = 2;
  localparam int XW     = $clog2(WORDS);
  localparam int HW     = XW - 1;
  localparam int SW     = $clog2(SETS);
  localparam int WW     = $clog2(WAYS);
  localparam int SET_LO = OFS + XW;
  localparam int TAG_LO = SET_LO + SW;
  localparam int TAGW   = AW - TAG_LO;
  localparam int WAW    = AW - OFS;

  dc_state_e      state;
  logic [WAW-1:0] r_wa;
  logic           r_we;
  logic [DW-1:0]  r_wdata;
  logic [XW-1:0]  beat;
  logic           half;
  logic [WW-1:0]  v_way;
  logic [1:0]     v_dirty;
  logic [TAGW-1:0] v_tag;

  logic [XW-1:0]   r_word;
  logic [SW-1:0]   r_set;
  logic [TAGW-1:0] r_tag;
  assign r_word = r_wa[0 +: XW];
  assign r_set  = r_wa[XW +: SW];
  assign r_tag  = r_wa[XW + SW +: TAGW];

  logic [WAYS-1:0]           hit_vec, valid_vec;
  logic [WAYS-1:0][1:0]      dirty_vec;
  logic [WAYS-1:0][TAGW-1:0] tag_vec;
  logic                      any_hit;
  logic [WW-1:0]             hit_way;
  logic [WW-1:0]             vic_way;
  logic                      vic_rr;
  logic [1:0]                vic_dirty;

  logic          fill_en, mark_en, adv;
  logic          d_wr_en;
  logic [WW-1:0] d_wr_way, d_rd_way;
  logic [XW-1:0] d_wr_word, d_rd_word;
  logic [DW-1:0] d_wr_data, d_rd_data;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++)
      if (hit_vec[i]) hit_way = WW'(i);
  end
  assign any_hit   = |hit_vec;
  assign vic_dirty = valid_vec[vic_way] ? dirty_vec[vic_way] : 2'b00;

  assign fill_en = (state == ST_FILL) && mem_ready && (beat == XW'(WORDS - 1));
  assign mark_en = (state == ST_LOOK) && any_hit && r_we;
  assign adv     = (state == ST_LOOK) && !any_hit && vic_rr;

  assign d_wr_en   = mark_en || ((state == ST_FILL) && mem_ready);
  assign d_wr_way  = (state == ST_FILL) ? v_way : hit_way;
  assign d_wr_word = (state == ST_FILL) ? beat : r_word;
  assign d_wr_data = (state == ST_FILL) ? mem_rdata : r_wdata;
  assign d_rd_way  = (state == ST_WBACK) ? v_way : hit_way;
  assign d_rd_word = (state == ST_WBACK) ? {half, beat[HW-1:0]} : r_word;

  dc_tagstore #(.SETS(SETS), .WAYS(WAYS), .TAGW(TAGW)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .look_set(r_set), .look_tag(r_tag),
    .hit_vec(hit_vec), .valid_vec(valid_vec),
    .dirty_vec(dirty_vec), .tag_vec(tag_vec),
    .fill_en(fill_en), .fill_way(v_way),
    .mark_en(mark_en), .mark_way(hit_way), .mark_half(r_word[XW-1])
  );

  dc_datastore #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .DW(DW)) u_data (
    .clk(clk), .set_idx(r_set),
    .wr_en(d_wr_en), .wr_way(d_wr_way), .wr_word(d_wr_word), .wr_data(d_wr_data),
    .rd_way(d_rd_way), .rd_word(d_rd_word), .rd_data(d_rd_data)
  );

  dc_victim #(.SETS(SETS), .WAYS(WAYS)) u_vic (
    .clk(clk), .rst_n(rst_n), .set_idx(r_set), .valid_vec(valid_vec),
    .adv(adv), .vic_way(vic_way), .use_rr(vic_rr)
  );

  // Output decode
  always_comb begin
    req_ready = (state == ST_IDLE);
    rsp_valid = 1'b0;
    rsp_rdata = d_rd_data;
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = d_rd_data;
    mem_last  = 1'b0;
    unique case (state)
      ST_LOOK: rsp_valid = any_hit;
      ST_WBACK: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {v_tag, r_set, half, beat[HW-1:0], {OFS{1'b0}}};
        mem_last  = (beat[HW-1:0] == {HW{1'b1}});
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {r_tag, r_set, beat, {OFS{1'b0}}};
        mem_last  = (beat == XW'(WORDS - 1));
      end
      ST_BYPASS: begin
        mem_valid = 1'b1;
        mem_we    = r_we;
        mem_addr  = {r_wa, {OFS{1'b0}}};
        mem_wdata = r_wdata;
        mem_last  = 1'b1;
        rsp_valid = mem_ready;
        rsp_rdata = mem_rdata;
      end
      default: ;
    endcase
  end

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      r_wa    <= '0;
      r_we    <= 1'b0;
      r_wdata <= '0;
      beat    <= '0;
      half    <= 1'b0;
      v_way   <= '0;
      v_dirty <= 2'b00;
      v_tag   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          r_wa    <= req_addr[AW-1:OFS];
          r_we    <= req_we;
          r_wdata <= req_wdata;
          state   <= cache_en ? ST_LOOK : ST_BYPASS;
        end
        ST_LOOK: begin
          if (any_hit) begin
            state <= ST_IDLE;
          end else begin
            v_way   <= vic_way;
            v_tag   <= tag_vec[vic_way];
            v_dirty <= vic_dirty;
            beat    <= '0;
            if (|vic_dirty) begin
              state <= ST_WBACK;
              half  <= !vic_dirty[0];
            end else begin
              state <= ST_FILL;
            end
          end
        end
        ST_WBACK: if (mem_ready) begin
          if (beat[HW-1:0] == {HW{1'b1}}) begin
            beat <= '0;
            if (!half && v_dirty[1]) half <= 1'b1;
            else state <= ST_FILL;
          end else begin
            beat <= beat + XW'(1);
          end
        end
        ST_FILL: if (mem_ready) begin
          if (beat == XW'(WORDS - 1)) begin
            beat  <= '0;
            state <= ST_LOOK;
          end else begin
            beat <= beat + XW'(1);
          end
        end
        ST_BYPASS: if (mem_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cache_en,
  input logic            req_valid,
  input logic            req_ready,
  input logic [AW-1:0]   req_addr,
  input logic            rsp_valid,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic            mem_last,
  input logic [WAYS-1:0] hit_vec
);
  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_valid && !rsp_valid)); // R1

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R9

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R9

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
      && $stable(mem_wdata) && $stable(mem_last))); // R10

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_last) |=>
      (mem_valid && (mem_we == $past(mem_we)) && (mem_addr == $past(mem_addr) + AW'(4)))); // R3

  AST_BYPASS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cache_en) |=>
      (mem_valid && mem_last && (mem_addr[AW-1:2] == $past(req_addr[AW-1:2])))); // R8
endmodule

bind hd_wb_dcache dc_checker #(.AW(AW), .DW(DW), .WAYS(WAYS)) u_dc_checker (
  .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .rsp_valid(rsp_valid),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_last(mem_last),
  .hit_vec(hit_vec)
);

// File: tb/tb_hd_wb_dcache.sv
`timescale 1ns/1ps
module tb_hd_wb_dcache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_last;
  logic [31:0] mem_rdata;

  always #10 clk = ~clk;

  hd_wb_dcache dut (.*);

  typedef struct packed { logic we; logic [31:0] addr; logic [31:0] data; logic last; } beat_t;

  logic [31:0] bmem [4096];
  logic [31:0] gold [4096];
  beat_t log_q[$];
  beat_t exp_q[$];

  bit          m_vld [16][4];
  logic [22:0] m_tag [16][4];
  bit [1:0]    m_drt [16][4];
  int          m_rr  [16];

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  assign mem_rdata = bmem[mem_addr[13:2]];

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      log_q.push_back('{mem_we, mem_addr, mem_we ? mem_wdata : 32'h0, mem_last});
      if (mem_we) bmem[mem_addr[13:2]] <= mem_wdata;
    end
    #1 mem_ready <= (($urandom % 10) < 7);
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired act=%0d exp<190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(int tg, int st, int wd);
    return {19'b0, 4'(tg), 4'(st), 3'(wd), 2'b00};
  endfunction

  // Requirement model: builds expected beats, updates model and gold memory.
  task automatic model(bit we, logic [31:0] a, logic [31:0] wd, bit cen,
                       output bit hit, output string tg);
    int s, w;
    logic [22:0] t;
    hit = 0;
    s = int'(a[8:5]);
    t = a[31:9];
    if (!cen) begin
      exp_q.push_back('{we, {a[31:2], 2'b00}, we ? wd : 32'h0, 1'b1});
      if (we) gold[a[13:2]] = wd;
      tg = "R8";
      return;
    end
    w = -1;
    for (int i = 0; i < 4; i++) if (m_vld[s][i] && m_tag[s][i] == t) w = i;
    if (w >= 0) begin
      hit = 1;
      tg = "R4/R2";
    end else begin
      tg = "R3/R7";
      for (int i = 3; i >= 0; i--) if (!m_vld[s][i]) w = i;
      if (w < 0) begin
        w = m_rr[s];
        m_rr[s] = (m_rr[s] + 1) % 4;
      end
      if (m_vld[s][w]) begin
        for (int h = 0; h < 2; h++)
          if (m_drt[s][w][h]) begin
            tg = "R6/R3/R7";
            for (int b = 0; b < 4; b++) begin
              logic [31:0] wa;
              wa = {m_tag[s][w], 4'(s), 1'(h), 2'(b), 2'b00};
              exp_q.push_back('{1'b1, wa, gold[wa[13:2]], b == 3});
            end
          end
      end
      for (int b = 0; b < 8; b++)
        exp_q.push_back('{1'b0, {t, 4'(s), 3'(b), 2'b00}, 32'h0, b == 7});
      m_vld[s][w] = 1;
      m_tag[s][w] = t;
      m_drt[s][w] = 2'b00;
    end
    if (we) begin
      m_drt[s][w][a[4]] = 1'b1;
      gold[a[13:2]] = wd;
    end
  endtask

  task automatic do_req(bit we, logic [31:0] a, logic [31:0] wd, bit cen);
    bit hit, busy_ok;
    string tg;
    logic [31:0] expd;
    int lat;
    bit same;
    expd = gold[a[13:2]];
    model(we, a, wd, cen, hit, tg);
    @(negedge clk);
    chk(req_ready, "R9 ready before request", 32'(req_ready), 32'h1);
    cache_en = cen; req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_ok = 1;
    while (!rsp_valid && lat < 400) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      lat++;
    end
    chk(rsp_valid && busy_ok, "R9 stall then response", 32'(rsp_valid), 32'h1);
    if (!we) chk(rsp_rdata == expd, $sformatf("R5 read data %s", tg), rsp_rdata, expd);
    if (hit) chk(lat == 1, "R4 hit latency", 32'(lat), 32'h1);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9 single pulse then idle", 32'({rsp_valid, req_ready}), 32'h1);
    same = (log_q.size() == exp_q.size());
    if (same)
      foreach (exp_q[i]) if (log_q[i] != exp_q[i]) same = 0;
    chk(same, $sformatf("%s/R10 memory beats", tg), 32'(log_q.size()), 32'(exp_q.size()));
    if (!same) begin
      foreach (log_q[i]) $display("  got  we=%0b a=%h d=%h l=%0b", log_q[i].we, log_q[i].addr, log_q[i].data, log_q[i].last);
      foreach (exp_q[i]) $display("  want we=%0b a=%h d=%h l=%0b", exp_q[i].we, exp_q[i].addr, exp_q[i].data, exp_q[i].last);
    end
    log_q.delete();
    exp_q.delete();
  endtask

  initial begin
    void'($urandom(32'd20241));
    for (int i = 0; i < 4096; i++) begin
      bmem[i] = 32'(i) * 32'h9E3779B1 ^ 32'h5A5A0F0F;
      gold[i] = bmem[i];
    end
    for (int s = 0; s < 16; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) begin m_vld[s][w] = 0; m_drt[s][w] = 0; m_tag[s][w] = '0; end
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mem_valid, "R1 reset outputs",
        32'({req_ready, rsp_valid, mem_valid}), 32'h4);
    // R1 R3 first access misses; R2 fill four ways of set 3, then re-read as hits
    for (int t = 0; t < 4; t++) do_req(0, mk(t, 3, t), 0, 1);
    for (int t = 0; t < 4; t++) do_req(0, mk(t, 3, 7 - t), 0, 1);
    // R5 store hit upper half of tag1; both halves of tag2; readback
    do_req(1, mk(1, 3, 5), 32'hCAFE0005, 1);
    do_req(1, mk(2, 3, 0), 32'hBEEF0000, 1);
    do_req(1, mk(2, 3, 7), 32'hBEEF0007, 1);
    do_req(0, mk(1, 3, 5), 0, 1);
    // R6 R7 three more tags: clean, upper-only, both-halves evictions
    for (int t = 4; t < 7; t++) do_req(0, mk(t, 3, 1), 0, 1);
    do_req(0, mk(1, 3, 5), 0, 1);
    // R5 store miss allocates
    do_req(1, mk(9, 6, 2), 32'h12345678, 1);
    do_req(0, mk(9, 6, 2), 0, 1);
    // R8 bypass read does not allocate; later cached read misses
    do_req(0, 32'h0000_2044, 0, 0);
    do_req(0, 32'h0000_2044, 0, 1);
    do_req(1, 32'h0000_3100, 32'hA5A5A5A5, 0);
    do_req(0, 32'h0000_3100, 0, 0);
    // Random mix, cached traffic on four sets, bypass in upper region
    for (int n = 0; n < 1500; n++) begin
      bit we, cen;
      logic [31:0] a;
      we  = ($urandom % 2) == 1;
      cen = ($urandom % 8) != 0;
      if (cen) a = mk($urandom % 8, ($urandom % 4) * 5, $urandom % 8);
      else     a = {18'b0, 1'b1, 11'($urandom), 2'b00};
      if (!cen && a[13:5] == 9'h102) a[12] = 1'b1;
      do_req(we, a, $urandom, cen);
    end
    summary();
    $finish;
  end
endmodule